// File: doc/BRIEF.md
# Receive Frame Elastic Store

This block sits between a recovered line clock and a local system clock. Serial payload from the line is written into a two-frame circular store, one bit per line clock. A pulse on the line side marks the first bit of each 256-bit frame. The system side reads the store out as a serial backplane of 32 eight-bit timeslots. It starts a read frame at its own frame pulse, or by itself once the previous 256 bits are out. Bits leave in the order they arrived, so the most significant bit of each timeslot is first.

When the two clocks drift apart, the distance between the write pointer and the start of the next read frame shrinks or grows. At each read frame start the block compares that distance with a lower and an upper limit. If the distance is too small, the frame just read is played again. If it is too large, one frame is skipped. Either case raises a sticky slip indication with a direction bit, which the system side clears with an acknowledge strobe. The block also reports the write-to-read frame offset, in whole timeslots.

The write pointer reaches the system clock domain as a Gray code through a chain of flip-flops. All slip decisions are taken in the system domain.

Top module: `elastic_store_rx`

## Requirements
- R1: During system reset, and afterwards until the first `sys_fp`, `sys_bit`, `slip_flag`, `slip_dir` and `delay_ts` are all 0.
- R2: Each line clock writes `line_bit` at the next store position, and the store wraps over 512 bits. When `line_fp` is high, that bit becomes bit 0 of a frame. If the write position is not already at a frame start, the write moves to the start of the other half.
- R3: After every system clock edge at which a frame starts, `sys_bit` carries bit 0 of that frame. The following 255 edges deliver the remaining bits in line order. Timeslot n of an output frame (bits 8n to 8n+7, MSB first) is timeslot n of one single line frame.
- R4: The first read frame after reset is taken from the half the writer is not filling. The first complete output frame therefore carries the first line frame written after reset.
- R5: If, at a read frame start, the write pointer is fewer than MIN_CH×8 bits ahead of the normal next frame, the previous frame is repeated and `slip_dir` is 0.
- R6: If that distance exceeds MAX_CH×8 bits, one frame is deleted and `slip_dir` is 1.
- R7: Slips occur only at read frame starts. When both clocks run at the same rate, no slip occurs and the output frame sequence advances by exactly one line frame per frame.
- R8: A slip sets `slip_flag` and keeps it set. `slip_ack` clears `slip_flag` and `slip_dir` at the next system edge. If a slip happens in the same cycle, the slip wins.
- R9: At each read frame start, `delay_ts` takes the write position within its frame divided by 8, which is the write-to-read offset in timeslots modulo one frame. It holds that value between frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| line_clk | input | 1 | Recovered line bit clock |
| line_rst | input | 1 | Synchronous active-high reset, line domain |
| line_bit | input | 1 | Serial line payload bit |
| line_fp | input | 1 | High with bit 0 of a line frame |
| sys_clk | input | 1 | System backplane bit clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| sys_fp | input | 1 | High for the edge that starts a backplane frame |
| slip_ack | input | 1 | Clears the slip indication |
| sys_bit | output | 1 | Serial backplane output bit |
| slip_flag | output | 1 | Sticky: a slip has occurred |
| slip_dir | output | 1 | 0 = frame repeated, 1 = frame deleted |
| delay_ts | output | 5 | Write-to-read offset in timeslots |

## Verification
The hard situation is a slip caused by real drift rather than by a forced pointer. The bench reaches it by running the line clock about 1.25 % fast or slow against the 125 MHz system clock for roughly a hundred frames, until the pointer distance crosses a limit. Every line frame carries its frame number in each timeslot, and each timeslot also carries its own index. From the recovered numbers the bench sees repeats and deletions, and it sees any break of timeslot alignment. It then compares each frame-to-frame step with the slip indication that was latched at that frame's start.

// File: rtl/es_pkg.sv
package es_pkg;
    localparam int ES_CH_BITS    = 8;
    localparam int ES_CHANNELS   = 32;
    localparam int ES_FRAME_BITS = ES_CHANNELS * ES_CH_BITS;
    localparam int ES_FRAMES     = 2;
    localparam int ES_DEPTH      = ES_FRAMES * ES_FRAME_BITS;
    localparam int ES_IDX_W      = $clog2(ES_FRAME_BITS);
    localparam int ES_PTR_W      = $clog2(ES_DEPTH);
    localparam int ES_TS_W       = $clog2(ES_CHANNELS);
    localparam int ES_SUB_W      = $clog2(ES_CH_BITS);

    typedef logic [ES_PTR_W-1:0] ptr_t;
    typedef logic [ES_IDX_W-1:0] idx_t;
    typedef logic [ES_TS_W-1:0]  ts_t;

    // store position: which frame half, and bit within the frame
    typedef struct packed {
        logic half;
        idx_t idx;
    } pos_t;

    typedef enum logic {
        SLIP_REPEAT = 1'b0,
        SLIP_DELETE = 1'b1
    } slip_e;

    function automatic ptr_t to_gray(ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t from_gray(ptr_t g);
        ptr_t b;
        b[ES_PTR_W-1] = g[ES_PTR_W-1];
        for (int i = ES_PTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic pos_t pos_step(pos_t p);
        return pos_t'(ptr_t'(p) + ptr_t'(1));
    endfunction

    function automatic ts_t idx_to_ts(idx_t i);
        return ts_t'(i >> ES_SUB_W);
    endfunction
endpackage

// File: rtl/es_wr_ctrl.sv
module es_wr_ctrl
    import es_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic line_fp,
    output pos_t wr_pos,
    output ptr_t wr_gray
);
    pos_t nxt_q;
    pos_t cur;
    pos_t after;

    // a frame pulse forces bit 0; if not already at a frame start, jump halves
    always_comb begin
        cur = nxt_q;
        if (line_fp) begin
            cur.idx = '0;
            if (nxt_q.idx != '0) begin
                cur.half = ~nxt_q.half;
            end
        end
        after = pos_step(cur);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt_q   <= '0;
            wr_gray <= '0;
        end else begin
            nxt_q   <= after;
            wr_gray <= to_gray(ptr_t'(after));
        end
    end

    assign wr_pos = cur;

    p_write_step_r2: assert property (@(posedge clk) disable iff (rst)
        !line_fp |=> ptr_t'(nxt_q) == ptr_t'($past(nxt_q)) + ptr_t'(1));

    p_gray_one_bit_r2: assert property (@(posedge clk) disable iff (rst)
        !line_fp |=> $countones(wr_gray ^ $past(wr_gray)) == 1);
endmodule

// File: rtl/es_gray_sync.sv
module es_gray_sync
    import es_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  ptr_t gray_in,
    output ptr_t bin_out
);
    ptr_t stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg_q[s] <= '0;
                else     stg_q[s] <= gray_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg_q[s] <= '0;
                else     stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign bin_out = from_gray(stg_q[STAGES-1]);
endmodule

// File: rtl/es_store.sv
module es_store
    import es_pkg::*;
(
    input  logic wclk,
    input  logic we,
    input  pos_t waddr,
    input  logic wdata,
    input  pos_t raddr,
    output logic rdata
);
    logic [ES_DEPTH-1:0] mem_q;

    always_ff @(posedge wclk) begin
        if (we) mem_q[ptr_t'(waddr)] <= wdata;
    end

    assign rdata = mem_q[ptr_t'(raddr)];
endmodule

// File: rtl/es_rd_ctrl.sv
module es_rd_ctrl
    import es_pkg::*;
#(
    parameter int MIN_CH = 2,
    parameter int MAX_CH = 60
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sys_fp,
    input  logic  slip_ack,
    input  ptr_t  wr_ptr,
    input  logic  rd_data,
    output pos_t  rd_pos,
    output logic  sys_bit,
    output logic  slip_flag,
    output slip_e slip_dir,
    output ts_t   delay_ts
);
    localparam ptr_t MIN_BITS = ptr_t'(MIN_CH * ES_CH_BITS);
    localparam ptr_t MAX_BITS = ptr_t'(MAX_CH * ES_CH_BITS);

    logic run_q;
    pos_t pos_q;
    pos_t pos_n;
    pos_t wr_view;
    logic start;
    logic advance;
    logic lag_lo;
    logic lag_hi;
    logic half_n;
    ptr_t dist_norm;

    always_comb begin
        wr_view   = pos_t'(wr_ptr);
        start     = sys_fp | (run_q & (pos_q.idx == '1));
        advance   = run_q | sys_fp;
        dist_norm = wr_ptr - ptr_t'({~pos_q.half, idx_t'(0)});
        lag_lo    = start & (dist_norm < MIN_BITS);
        lag_hi    = start & (dist_norm > MAX_BITS);
        // both slips land on the same half in a two-frame store
        half_n    = (lag_lo | lag_hi) ? pos_q.half : ~pos_q.half;
        pos_n     = pos_q;
        if (start) begin
            pos_n.half = half_n;
            pos_n.idx  = '0;
        end else if (advance) begin
            pos_n = pos_step(pos_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            pos_q     <= '0;
            sys_bit   <= 1'b0;
            slip_flag <= 1'b0;
            slip_dir  <= SLIP_REPEAT;
            delay_ts  <= '0;
        end else begin
            run_q <= run_q | sys_fp;
            pos_q <= pos_n;
            if (advance) sys_bit <= rd_data;
            if (start) delay_ts <= idx_to_ts(wr_view.idx);
            if (lag_lo | lag_hi) begin
                slip_flag <= 1'b1;
                slip_dir  <= lag_hi ? SLIP_DELETE : SLIP_REPEAT;
            end else if (slip_ack) begin
                slip_flag <= 1'b0;
                slip_dir  <= SLIP_REPEAT;
            end
        end
    end

    assign rd_pos = pos_n;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> (!sys_bit && !slip_flag));

    p_read_step_r3: assert property (@(posedge clk) disable iff (rst)
        (run_q && !start) |=> ptr_t'(pos_q) == ptr_t'($past(pos_q)) + ptr_t'(1));

    p_slip_on_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(slip_flag) |-> (pos_q.idx == '0));

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (slip_ack && !start) |=> !slip_flag);

    p_dir_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (slip_dir == SLIP_DELETE) |-> slip_flag);

    p_delay_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(delay_ts));
endmodule

// File: rtl/elastic_store_rx.sv
module elastic_store_rx
    import es_pkg::*;
#(
    parameter int MIN_CH      = 2,
    parameter int MAX_CH      = 60,
    parameter int SYNC_STAGES = 2
) (
    input  logic       line_clk,
    input  logic       line_rst,
    input  logic       line_bit,
    input  logic       line_fp,
    input  logic       sys_clk,
    input  logic       sys_rst,
    input  logic       sys_fp,
    input  logic       slip_ack,
    output logic       sys_bit,
    output logic       slip_flag,
    output logic       slip_dir,
    output logic [4:0] delay_ts
);
    pos_t  wr_pos;
    pos_t  rd_pos;
    ptr_t  wr_gray;
    ptr_t  wr_ptr_sys;
    logic  rd_data;
    slip_e dir_e;
    ts_t   delay_int;

    es_wr_ctrl u_wr (
        .clk     (line_clk),
        .rst     (line_rst),
        .line_fp (line_fp),
        .wr_pos  (wr_pos),
        .wr_gray (wr_gray)
    );

    es_store u_store (
        .wclk  (line_clk),
        .we    (~line_rst),
        .waddr (wr_pos),
        .wdata (line_bit),
        .raddr (rd_pos),
        .rdata (rd_data)
    );

    es_gray_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (sys_clk),
        .rst     (sys_rst),
        .gray_in (wr_gray),
        .bin_out (wr_ptr_sys)
    );

    es_rd_ctrl #(.MIN_CH(MIN_CH), .MAX_CH(MAX_CH)) u_rd (
        .clk       (sys_clk),
        .rst       (sys_rst),
        .sys_fp    (sys_fp),
        .slip_ack  (slip_ack),
        .wr_ptr    (wr_ptr_sys),
        .rd_data   (rd_data),
        .rd_pos    (rd_pos),
        .sys_bit   (sys_bit),
        .slip_flag (slip_flag),
        .slip_dir  (dir_e),
        .delay_ts  (delay_int)
    );

    assign slip_dir = dir_e;
    assign delay_ts = delay_int;
endmodule

// File: tb/elastic_store_rx_tb.sv
module elastic_store_rx_tb;
    logic line_clk = 1'b0, sys_clk = 1'b0;
    logic line_rst = 1'b1, sys_rst = 1'b1;
    logic line_bit = 1'b0, line_fp = 1'b0, sys_fp = 1'b0, slip_ack = 1'b0;
    logic sys_bit, slip_flag, slip_dir;
    logic [4:0] delay_ts;

    int line_half = 4000;
    bit line_run = 0, sys_run = 0, mon_en = 0;
    int checks = 0, errors = 0;

    // monitor statistics
    int cur_idx, bitcnt, prev_fn, first_fn, first_delay, prev_delay;
    int align_err, seq_err, n_rep, n_del, delay_chg, ack_err, frames;
    logic cur_flag, cur_dir, ack_pend, fp_d;
    logic [4:0] cur_delay;
    logic [7:0] fb [32];

    elastic_store_rx u_dut (
        .line_clk(line_clk), .line_rst(line_rst), .line_bit(line_bit), .line_fp(line_fp),
        .sys_clk(sys_clk), .sys_rst(sys_rst), .sys_fp(sys_fp), .slip_ack(slip_ack),
        .sys_bit(sys_bit), .slip_flag(slip_flag), .slip_dir(slip_dir), .delay_ts(delay_ts)
    );

    initial forever #4000 sys_clk = ~sys_clk;
    initial begin
        #1000;
        forever #(line_half) line_clk = ~line_clk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // line source: byte of timeslot t in frame n is {n[2:0], t[4:0]}, MSB first
    initial begin
        int lcnt = 0;
        int lfn = 0;
        logic [7:0] byte_v;
        forever begin
            @(negedge line_clk);
            if (!line_run) begin
                lcnt = 0; lfn = 0; line_fp = 1'b0; line_bit = 1'b0;
            end else begin
                byte_v   = {3'(lfn), 5'(lcnt / 8)};
                line_fp  = (lcnt == 0);
                line_bit = byte_v[7 - (lcnt % 8)];
                lcnt++;
                if (lcnt == 256) begin
                    lcnt = 0;
                    lfn++;
                end
            end
        end
    end

    initial begin
        int scnt = 0;
        forever begin
            @(negedge sys_clk);
            if (!sys_run) begin
                scnt = 0; sys_fp = 1'b0;
            end else begin
                sys_fp = (scnt == 0);
                scnt = (scnt + 1) % 256;
            end
        end
    end

    always @(posedge sys_clk) fp_d <= sys_fp;

    task automatic eval_frame();
        int fn;
        int delta;
        int expd;
        fn = int'(fb[0][7:5]);
        for (int t = 0; t < 32; t++) begin
            if (fb[t][4:0] != 5'(t) || int'(fb[t][7:5]) != fn) align_err++;
        end
        if (cur_idx == 1) begin
            first_fn = fn;
            first_delay = int'(cur_delay);
        end
        if (cur_idx >= 2) begin
            delta = (fn - prev_fn) & 7;
            expd  = cur_flag ? (cur_dir ? 2 : 0) : 1;
            if (delta != expd) seq_err++;
            if (!cur_flag && int'(cur_delay) != prev_delay) delay_chg++;
        end
        prev_fn = fn;
        prev_delay = int'(cur_delay);
        frames++;
    endtask

    always @(negedge sys_clk) begin
        if (!mon_en) begin
            cur_idx = -1; bitcnt = 0; slip_ack = 1'b0; ack_pend = 1'b0;
        end else begin
            if (ack_pend && slip_flag) ack_err++;
            ack_pend = slip_ack;
            slip_ack = 1'b0;
            if (fp_d) begin
                if (bitcnt == 256 && cur_idx >= 1) eval_frame();
                cur_idx++;
                cur_flag  = slip_flag;
                cur_dir   = slip_dir;
                cur_delay = delay_ts;
                if (slip_flag) begin
                    if (slip_dir) n_del++;
                    else n_rep++;
                    slip_ack = 1'b1;
                end
                bitcnt = 0;
            end
            if (cur_idx >= 0 && bitcnt < 256) begin
                fb[bitcnt / 8] = {fb[bitcnt / 8][6:0], sys_bit};
                bitcnt++;
            end
        end
    end

    task automatic do_reset();
        line_run = 0; sys_run = 0; mon_en = 0;
        @(negedge sys_clk);
        line_rst = 1'b1; sys_rst = 1'b1;
        repeat (8) @(negedge sys_clk);
        line_rst = 1'b0; sys_rst = 1'b0;
        align_err = 0; seq_err = 0; n_rep = 0; n_del = 0; delay_chg = 0;
        ack_err = 0; frames = 0; first_fn = -1; first_delay = -1;
    endtask

    task automatic start_streams(input int offset);
        line_run = 1;
        repeat (offset) @(negedge sys_clk);
        sys_run = 1;
        mon_en = 1;
    endtask

    task automatic test_reset();
        line_half = 4000;
        do_reset();
        @(negedge sys_clk);
        check(slip_flag == 1'b0, "R1 flag after reset", int'(slip_flag), 0);
        check(slip_dir == 1'b0, "R1 dir after reset", int'(slip_dir), 0);
        check(delay_ts == 5'd0, "R1 delay after reset", int'(delay_ts), 0);
        line_run = 1;
        repeat (40) @(negedge sys_clk);
        check(sys_bit == 1'b0, "R1 output idle before first sys_fp", int'(sys_bit), 0);
        check(slip_flag == 1'b0, "R1 no slip before first sys_fp", int'(slip_flag), 0);
    endtask

    task automatic test_equal_rate();
        line_half = 4000;
        do_reset();
        start_streams(64);
        repeat (20 * 256) @(posedge sys_clk);
        @(negedge sys_clk);
        check(frames >= 17, "R3 frames collected", frames, 17);
        check(align_err == 0, "R2 R3 timeslot alignment equal rate", align_err, 0);
        check(first_fn == 0, "R4 first full frame is line frame 0", first_fn, 0);
        check(seq_err == 0, "R7 frame sequence equal rate", seq_err, 0);
        check(n_rep + n_del == 0, "R7 no slips at equal rate", n_rep + n_del, 0);
        check(first_delay >= 6 && first_delay <= 8, "R9 delay near 8 timeslots", first_delay, 7);
        check(delay_chg == 0, "R9 delay steady at equal rate", delay_chg, 0);
    endtask

    task automatic test_fast_line();
        line_half = 3950;
        do_reset();
        start_streams(64);
        repeat (70 * 256) @(posedge sys_clk);
        @(negedge sys_clk);
        check(n_del >= 1, "R6 delete slip with fast line", n_del, 1);
        check(n_rep == 0, "R6 no repeat with fast line", n_rep, 0);
        check(seq_err == 0, "R6 R7 frame skipped exactly once per slip", seq_err, 0);
        check(align_err == 0, "R3 alignment kept over delete", align_err, 0);
        check(ack_err == 0, "R8 ack clears flag after delete", ack_err, 0);
    endtask

    task automatic test_slow_line();
        line_half = 4050;
        do_reset();
        start_streams(64);
        repeat (120 * 256) @(posedge sys_clk);
        @(negedge sys_clk);
        check(n_rep >= 1, "R5 repeat slip with slow line", n_rep, 1);
        check(n_del == 0, "R5 no delete with slow line", n_del, 0);
        check(seq_err == 0, "R5 R7 frame repeated exactly once per slip", seq_err, 0);
        check(align_err == 0, "R3 alignment kept over repeat", align_err, 0);
        check(ack_err == 0, "R8 ack clears flag after repeat", ack_err, 0);
    endtask

    initial begin
        repeat (190000) @(posedge sys_clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_equal_rate();
        test_fast_line();
        test_slow_line();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule